// File: doc/BRIEF.md
# Residue Number System Multiply-Accumulate Pipeline

This block is a multiply-accumulate datapath that keeps every value in residue form over four independent channels with moduli 2, 3, 5 and 7. Because these moduli share no common factor, the four channels together cover 210 distinct values, which is the dynamic range of the accumulator. Each channel is held as a one-hot vector as wide as its modulus. A modular multiply or add then maps each one-hot input line to exactly one output line, selected by the other operand. No carry ever moves between channels.

Each accepted operation carries an activation, a weight, a bias and a select bit. The block multiplies activation by weight in every channel. It adds the product either to the running accumulator or to the bias, and writes the sum back into the accumulator. The work runs through five register stages: operand load, multiply, addend decode, add, and write-back. A new operation can enter every cycle. Back-to-back accumulates see the sum of the previous operation through a forwarding path from the add stage, so no update is lost. A clear input resets the accumulator to residue zero.

Top module: `rns_mac`

## Requirements
- R1: Each residue bus has four 7-bit fields. Channel c occupies bits [7c+6:7c], for channel 0 modulus 2, channel 1 modulus 3, channel 2 modulus 5 and channel 3 modulus 7. Residue r is encoded with only bit r of the field set, and the field bits at and above the modulus are zero. A negative value -X is stored per channel as (m - X mod m) mod m, so the results equal the integer results taken modulo 210.
- R2: An operation presented with inValid high before rising edge k gives outValid high and its result on outSum after rising edge k+4. The result is visible five edges after it was sampled, counting the sampling edge.
- R3: With inSel high, the result is (bias + activation × weight) mod 210.
- R4: With inSel low, the result is (previous accumulator + activation × weight) mod 210. The previous accumulator is the result of the most recent earlier operation, or zero after reset or clear.
- R5: Operations may be accepted on consecutive cycles. Every accumulate then builds on the result of the operation just before it.
- R6: accClear high before a rising edge sets all four channels of the accumulator to residue 0 at that edge, visible on outSum right after it. accClear is only raised while no operation is in the pipeline.
- R7: After reset, outValid is low and outSum holds residue 0 in every channel.
- R8: Every field of outSum always has exactly one bit set, and that bit lies below its channel's modulus.
- R9: While no result is being delivered, outValid is low and outSum keeps showing the most recent written result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation present this cycle |
| inSel | input | 1 | 1: add product to bias, 0: add product to accumulator |
| inAct | input | 28 | Activation, one-hot residue bus |
| inWeight | input | 28 | Weight, one-hot residue bus |
| inBias | input | 28 | Bias, one-hot residue bus |
| accClear | input | 1 | Reset the accumulator to residue zero |
| outValid | output | 1 | outSum carries a new result |
| outSum | output | 28 | Accumulator, one-hot residue bus |

## Verification
The assertions assume that every operand field is exactly one-hot while inValid is high, and that accClear arrives only when the pipeline holds no operation and no operation is entering. The stimulus converts each integer operand to residues with its own encoder, so every field has one bit set. Idle cycles drive residue zero. Before each clear, the stimulus runs enough idle cycles to empty all five stages. The random mix of bias loads, accumulate runs, gaps and negative operands stays inside these limits.

// File: rtl/rns_mac_pkg.sv
package rns_mac_pkg;
  localparam int NUM_CH = 4;
  localparam int MAX_W  = 7;
  localparam int BUS_W  = NUM_CH * MAX_W;

  function automatic int chMod(input int c);
    case (c)
      0:       return 2;
      1:       return 3;
      2:       return 5;
      default: return 7;
    endcase
  endfunction

  typedef struct packed {
    logic en1;       // load operands
    logic en2;       // form product
    logic en3;       // decode addend
    logic en4;       // perform add
    logic useBias4;  // addend is the bias
    logic fwd4;      // previous sum still in the add-stage register
    logic wb5;       // write sum into accumulator
    logic clr;       // clear accumulator
  } strobeT;
endpackage

// File: rtl/rns_lane.sv
module rns_lane
  import rns_mac_pkg::*;
#(
  parameter int MOD = 5
) (
  input  logic           clk,
  input  logic           rstN,
  input  strobeT         st,
  input  logic [MOD-1:0] actIn,
  input  logic [MOD-1:0] wtIn,
  input  logic [MOD-1:0] biasIn,
  output logic [MOD-1:0] accOut
);
  localparam logic [MOD-1:0] ZERO_OH = MOD'(1);

  function automatic logic [MOD-1:0] ohMul(input logic [MOD-1:0] a, input logic [MOD-1:0] b);
    logic [MOD-1:0] r;
    r = '0;
    for (int i = 0; i < MOD; i++)
      for (int k = 0; k < MOD; k++)
        if (a[i] && b[k]) r[(i * k) % MOD] = 1'b1;
    return r;
  endfunction

  function automatic logic [MOD-1:0] ohAdd(input logic [MOD-1:0] a, input logic [MOD-1:0] b);
    logic [MOD-1:0] r;
    r = '0;
    for (int i = 0; i < MOD; i++)
      for (int k = 0; k < MOD; k++)
        if (a[i] && b[k]) r[(i + k) % MOD] = 1'b1;
    return r;
  endfunction

  logic [MOD-1:0] act1, wt1, bias1;
  logic [MOD-1:0] prod2, bias2;
  logic [MOD-1:0] prod3, bias3;
  logic [MOD-1:0] sum4, acc;
  logic [MOD-1:0] partial, addend;

  always_comb begin
    partial = st.fwd4 ? sum4 : acc;
    addend  = st.useBias4 ? bias3 : partial;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      act1 <= ZERO_OH; wt1 <= ZERO_OH; bias1 <= ZERO_OH;
      prod2 <= ZERO_OH; bias2 <= ZERO_OH;
      prod3 <= ZERO_OH; bias3 <= ZERO_OH;
      sum4 <= ZERO_OH;
      acc <= ZERO_OH;
    end else begin
      if (st.en1) begin
        act1  <= actIn;
        wt1   <= wtIn;
        bias1 <= biasIn;
      end
      if (st.en2) begin
        prod2 <= ohMul(act1, wt1);
        bias2 <= bias1;
      end
      if (st.en3) begin
        prod3 <= prod2;
        bias3 <= bias2;
      end
      if (st.en4) sum4 <= ohAdd(prod3, addend);
      if (st.clr) acc <= ZERO_OH;
      else if (st.wb5) acc <= sum4;
    end
  end

  assign accOut = acc;

  a_r1_operand_onehot: assert property (@(posedge clk) disable iff (!rstN)
    st.en1 |-> ($countones(actIn) == 1 && $countones(wtIn) == 1 && $countones(biasIn) == 1));

  a_r8_acc_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $countones(acc) == 1);

  a_r6_clear_to_zero: assert property (@(posedge clk) disable iff (!rstN)
    st.clr |=> acc == ZERO_OH);

  a_r5_writeback: assert property (@(posedge clk) disable iff (!rstN)
    (st.wb5 && !st.clr) |=> acc == $past(sum4));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!st.wb5 && !st.clr) |=> $stable(acc));
endmodule

// File: rtl/rns_ctrl.sv
module rns_ctrl
  import rns_mac_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   inValid,
  input  logic   inSel,
  input  logic   accClear,
  output strobeT st,
  output logic   outValid
);
  logic [5:1] vld;
  logic [3:1] sel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld <= '0;
      sel <= '0;
    end else begin
      vld <= {vld[4:1], inValid};
      sel <= {sel[2:1], inSel};
    end
  end

  always_comb begin
    st.en1      = inValid;
    st.en2      = vld[1];
    st.en3      = vld[2];
    st.en4      = vld[3];
    st.useBias4 = sel[3];
    st.fwd4     = vld[4];
    st.wb5      = vld[4];
    st.clr      = accClear;
  end

  assign outValid = vld[5];

  a_r2_latency: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##5 outValid);

  a_r6_clear_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    accClear |-> (vld[4:1] == 4'b0 && !inValid));
endmodule

// File: rtl/rns_datapath.sv
module rns_datapath
  import rns_mac_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           st,
  input  logic [BUS_W-1:0] inAct,
  input  logic [BUS_W-1:0] inWeight,
  input  logic [BUS_W-1:0] inBias,
  output logic [BUS_W-1:0] outSum
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int M = chMod(c);
    rns_lane #(.MOD(M)) u_lane (
      .clk    (clk),
      .rstN   (rstN),
      .st     (st),
      .actIn  (inAct[c*MAX_W +: M]),
      .wtIn   (inWeight[c*MAX_W +: M]),
      .biasIn (inBias[c*MAX_W +: M]),
      .accOut (outSum[c*MAX_W +: M])
    );
    if (M < MAX_W) begin : g_pad
      assign outSum[c*MAX_W+M +: MAX_W-M] = '0;
    end
  end
endmodule

// File: rtl/rns_mac.sv
module rns_mac
  import rns_mac_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inSel,
  input  logic [BUS_W-1:0] inAct,
  input  logic [BUS_W-1:0] inWeight,
  input  logic [BUS_W-1:0] inBias,
  input  logic             accClear,
  output logic             outValid,
  output logic [BUS_W-1:0] outSum
);
  strobeT st;

  rns_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inSel    (inSel),
    .accClear (accClear),
    .st       (st),
    .outValid (outValid)
  );

  rns_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .inAct    (inAct),
    .inWeight (inWeight),
    .inBias   (inBias),
    .outSum   (outSum)
  );
endmodule

// File: tb/rns_mac_bench.sv
`timescale 1ns/1ps
module rns_mac_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inSel = 1'b0;
  logic [27:0] inAct = '0, inWeight = '0, inBias = '0;
  logic        accClear = 1'b0;
  logic        outValid;
  logic [27:0] outSum;

  int checks = 0;
  int errors = 0;
  int refAcc = 0;

  bit          expV[5];
  logic [27:0] expS[5];
  string       expT[5];

  rns_mac u_rns_mac (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSel(inSel),
    .inAct(inAct), .inWeight(inWeight), .inBias(inBias),
    .accClear(accClear), .outValid(outValid), .outSum(outSum)
  );

  always #2.5 clk = ~clk;

  function automatic int benchMod(input int c);
    int mods[4] = '{2, 3, 5, 7};
    return mods[c];
  endfunction

  function automatic int wrap210(input int x);
    return ((x % 210) + 210) % 210;
  endfunction

  function automatic logic [27:0] toRns(input int x);
    logic [27:0] r;
    int v;
    r = '0;
    v = wrap210(x);
    for (int c = 0; c < 4; c++) r[c*7 + (v % benchMod(c))] = 1'b1;
    return r;
  endfunction

  task automatic checkVal(input string tag, input logic [27:0] act, input logic [27:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outSum actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkOneHot();
    bit good;
    good = 1'b1;
    for (int c = 0; c < 4; c++) begin
      if ($countones(outSum[c*7 +: 7]) != 1) good = 1'b0;
      if ((outSum[c*7 +: 7] >> benchMod(c)) != 0) good = 1'b0;
    end
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL R8: outSum actual %h expected one bit per field below modulus", outSum);
    end
  endtask

  // one cycle: check what is due, then drive the next operation
  task automatic step(input bit v, input bit s, input int a, input int w,
                      input int b, input bit clr, input string tag);
    @(negedge clk);
    checks++;
    if (outValid !== expV[4]) begin
      errors++;
      $display("FAIL R2: outValid actual %0b expected %0b", outValid, expV[4]);
    end
    checkVal(expT[4], outSum, expS[4]);
    checkOneHot();
    for (int i = 4; i > 0; i--) begin
      expV[i] = expV[i-1]; expS[i] = expS[i-1]; expT[i] = expT[i-1];
    end
    inValid  = v;
    inSel    = s;
    inAct    = toRns(v ? a : 0);
    inWeight = toRns(v ? w : 0);
    inBias   = toRns(v ? b : 0);
    accClear = clr;
    if (v) begin
      if (s) refAcc = wrap210(b + a * w);
      else   refAcc = wrap210(refAcc + a * w);
    end
    if (clr) refAcc = 0;
    expV[0] = v;
    expS[0] = toRns(refAcc);
    expT[0] = v ? tag : "R9";
    if (clr) begin
      for (int i = 0; i < 5; i++) begin
        expV[i] = 1'b0; expS[i] = toRns(0); expT[i] = "R6";
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, "R9");
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 5; i++) begin
      expV[i] = 1'b0; expS[i] = toRns(0); expT[i] = "R9";
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R7 reset state
    checks++;
    if (outValid !== 1'b0) begin
      errors++;
      $display("FAIL R7: outValid actual %0b expected 0", outValid);
    end
    checkVal("R7", outSum, toRns(0));

    // R1 encoding examples, including a negative operand
    step(1, 1, 20, 5, 0, 0, "R1");
    step(1, 1, 20, 1, 5, 0, "R1");
    step(1, 1, -20, 1, 0, 0, "R1");
    step(1, 1, -4, -6, -1, 0, "R3");
    // R5 back-to-back accumulates
    step(1, 1, 2, 3, 3, 0, "R3");
    for (int i = 0; i < 8; i++) step(1, 0, i + 1, 7 - i, 0, 0, "R5");
    idle(6);

    // R6 clear, then accumulate from zero
    step(0, 0, 0, 0, 0, 1, "R6");
    step(1, 0, 4, 9, 0, 0, "R6");
    step(1, 0, 11, 13, 0, 0, "R5");
    idle(6);

    // extremes of the range
    step(1, 1, 209, 209, 209, 0, "R3");
    step(1, 0, 105, 2, 0, 0, "R4");
    step(1, 0, -105, -105, 0, 0, "R4");
    idle(6);

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      bit v, s;
      int a, w, b;
      v = ($urandom_range(3, 0) != 0);
      s = ($urandom_range(3, 0) == 0);
      a = int'($urandom_range(209, 0)) - 104;
      w = int'($urandom_range(209, 0)) - 104;
      b = int'($urandom_range(209, 0));
      step(v, s, a, w, b, 0, s ? "R3" : "R4");
      if (n == 200) begin
        idle(6);
        step(0, 0, 0, 0, 0, 1, "R6");
      end
    end
    idle(7);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule